// File: doc/BRIEF.md
# Equalization Preset Override Selector

This block decides, for every equalization situation of a serial link, which 4-bit transmitter preset is put on the local transmitter and which preset is sent back to the remote transmitter inside training sets. It reads a 32-bit control word together with the link's live state: endpoint or root-port mode, the current rate (rate 3 or rate 4), the equalization phase, the iteration counter within the phase, a flag that marks the receiver-config substate of recovery during a rate-3 to rate-4 speed change, the preset the partner advertised, and the preset that the normal equalization engine picked.

The control word holds a local override preset for each rate, a remote feedback preset for each rate, and a request to send the special TS2 during the speed change. Local overrides act in either mode. Remote feedback and the special TS2 act in endpoint mode only. The training-set framing, the preset-to-coefficient mapping, the link state machine and register access are outside this block. Every output is registered, so each answer shows up one clock after the inputs it depends on.

Top module: `eqp_override_sel`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all outputs go to zero after that edge. This covers `local_preset`, `remote_preset`, `fb_valid` and `use_eq_ts2`.
- R2: At rate 3 (`rate_is_g4`=0), if control bit 5 is set, `local_preset` carries control bits 9:6. This holds in both modes.
- R3: At rate 4 (`rate_is_g4`=1), if control bit 16 is set, `local_preset` carries control bits 20:17. This holds in both modes.
- R4: If the current rate has no local override enabled, `local_preset` equals `engine_preset`.
- R5: At rate 3, `fb_valid` rises and `remote_preset` carries control bits 4:1 when all of these hold: control bit 0 is set, the mode is endpoint, `eq_phase` is 2 and `eq_iter` is 0.
- R6: At rate 4, `fb_valid` rises and `remote_preset` carries control bits 15:12 when all of these hold: control bit 11 is set, the mode is endpoint, `eq_phase` is 2, `eq_iter` is 0, and the preset differs from `partner_preset`.
- R7: At rate 4, if `partner_preset` equals control bits 15:12, the feedback is skipped and `fb_valid` stays low.
- R8: `fb_valid` is low whenever `eq_phase` is not 2 or `eq_iter` is not 0.
- R9: `use_eq_ts2` is high exactly when all of these hold: the mode is endpoint, the rate is 3, control bit 10 is set, and `spd_chg_rcfg` is high. In that case, if no feedback is valid, `remote_preset` carries control bits 15:12.
- R10: In root-port mode (`is_endpoint`=0), control bits 0, 10 and 11 have no effect: `fb_valid` and `use_eq_ts2` stay low. Whenever neither feedback nor the special TS2 is active, `remote_preset` is 0.
- R11: Control bits 31:21 have no effect on any output.
- R12: Each output reflects the inputs sampled at the previous rising edge, so a change to the control word shows on the cycle after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_word | input | 32 | Override and feedback control word |
| is_endpoint | input | 1 | 1 = endpoint mode, 0 = root-port mode |
| rate_is_g4 | input | 1 | 0 = link at rate 3, 1 = link at rate 4 |
| eq_phase | input | 2 | Current equalization phase (0 to 3) |
| eq_iter | input | ITER_W | Iteration counter within the phase, 0 = first |
| spd_chg_rcfg | input | 1 | In receiver-config of recovery during the rate-3 to rate-4 change |
| partner_preset | input | 4 | Preset the partner advertised when phase 2 began |
| engine_preset | input | 4 | Preset chosen by the normal equalization engine |
| local_preset | output | 4 | Preset applied to the local transmitter |
| remote_preset | output | 4 | Preset fed back to the remote transmitter |
| use_eq_ts2 | output | 1 | Send the special equalization TS2 instead of a standard TS2 |
| fb_valid | output | 1 | `remote_preset` is a valid phase-2 feedback request |

## Verification
The assertions compare registered outputs with the inputs from the previous edge. They therefore assume the inputs are stable around each rising edge and free of unknown values from the first clock after reset. The bench meets this by driving every input only on the falling edge and assigning all of them a value before reset is released. The random stimulus biases the phase toward 2, the iteration counter toward 0 and the partner preset toward the rate-4 feedback value, so that the narrow feedback and skip conditions come up often. Directed cases then toggle the reserved bits and the root-port mode alone.

// File: rtl/eqp_pkg.sv
// Package: shared preset type, decoded control fields and phase encoding
// for the equalization preset override selector. Field positions in the
// control word are fixed by the decoder; nothing here is configurable by
// software beyond the word itself.
package eqp_pkg;
    localparam int PRESET_W = 4;
    localparam int CTRL_W   = 32;
    localparam int N_RATES  = 2;   // index 0 = rate 3, index 1 = rate 4
    localparam logic [1:0] PHASE_TWO = 2'd2;

    typedef logic [PRESET_W-1:0] preset_t;

    typedef struct packed {
        logic    g3_fb_en;
        preset_t g3_fb;
        logic    g3_ovr_en;
        preset_t g3_ovr;
        logic    ts2_en;
        logic    g4_fb_en;
        preset_t g4_fb;
        logic    g4_ovr_en;
        preset_t g4_ovr;
    } eq_ctrl_t;
endpackage

// File: rtl/eqp_ctrl_decode.sv
// Module: eqp_ctrl_decode
// Splits the raw control word into named fields. Purely combinational.
// Assumes the word layout fixed by the block; the reserved upper bits are
// dropped here so no later stage can depend on them.
module eqp_ctrl_decode
    import eqp_pkg::*;
(
    input  logic [CTRL_W-1:0] word_i,
    output eq_ctrl_t          fields_o
);
    logic unused_rsvd;

    // Map each bit range of the word onto its field.
    always_comb begin
        fields_o.g3_fb_en  = word_i[0];
        fields_o.g3_fb     = word_i[4:1];
        fields_o.g3_ovr_en = word_i[5];
        fields_o.g3_ovr    = word_i[9:6];
        fields_o.ts2_en    = word_i[10];
        fields_o.g4_fb_en  = word_i[11];
        fields_o.g4_fb     = word_i[15:12];
        fields_o.g4_ovr_en = word_i[16];
        fields_o.g4_ovr    = word_i[20:17];
    end

    assign unused_rsvd = ^word_i[CTRL_W-1:21];
endmodule

// File: rtl/eqp_local_sel.sv
// Module: eqp_local_sel
// Chooses the local transmitter preset. Per-rate override slots are built
// with a generate loop; the slot for the current rate wins when enabled,
// otherwise the equalization engine's preset passes through. Mode-agnostic.
module eqp_local_sel
    import eqp_pkg::*;
(
    input  eq_ctrl_t fields_i,
    input  logic     rate_is_g4_i,
    input  preset_t  engine_i,
    output preset_t  local_o
);
    logic    ovr_en  [N_RATES];
    preset_t ovr_val [N_RATES];

    for (genvar r = 0; r < N_RATES; r++) begin : g_slot
        if (r == 0) begin : g_rate3
            assign ovr_en[r]  = fields_i.g3_ovr_en;
            assign ovr_val[r] = fields_i.g3_ovr;
        end else begin : g_rate4
            assign ovr_en[r]  = fields_i.g4_ovr_en;
            assign ovr_val[r] = fields_i.g4_ovr;
        end
    end

    // Select the override of the active rate or pass the engine result.
    always_comb begin
        local_o = engine_i;
        if (ovr_en[rate_is_g4_i]) local_o = ovr_val[rate_is_g4_i];
    end
endmodule

// File: rtl/eqp_remote_sel.sv
// Module: eqp_remote_sel
// Decides phase-2 first-iteration feedback and the special TS2 request.
// Both are endpoint-only. Rate-4 feedback is skipped when the partner
// already advertised the same preset. Feedback has priority over the TS2
// preset on the shared remote preset output; idle value is zero.
module eqp_remote_sel
    import eqp_pkg::*;
#(
    parameter int ITER_W = 3
) (
    input  eq_ctrl_t          fields_i,
    input  logic              is_endpoint_i,
    input  logic              rate_is_g4_i,
    input  logic [1:0]        phase_i,
    input  logic [ITER_W-1:0] iter_i,
    input  logic              spd_chg_rcfg_i,
    input  preset_t           partner_i,
    output preset_t           remote_o,
    output logic              fb_valid_o,
    output logic              ts2_o
);
    logic first_p2;
    logic g3_fb_hit;
    logic g4_fb_hit;

    // Qualify the feedback window and each rate's feedback request.
    always_comb begin
        first_p2  = is_endpoint_i && (phase_i == PHASE_TWO) && (iter_i == '0);
        g3_fb_hit = first_p2 && !rate_is_g4_i && fields_i.g3_fb_en;
        g4_fb_hit = first_p2 && rate_is_g4_i && fields_i.g4_fb_en
                    && (partner_i != fields_i.g4_fb);
        fb_valid_o = g3_fb_hit || g4_fb_hit;
        ts2_o      = is_endpoint_i && !rate_is_g4_i && fields_i.ts2_en
                     && spd_chg_rcfg_i;
    end

    // Drive the remote preset from the active source, feedback first.
    always_comb begin
        remote_o = '0;
        if (g3_fb_hit)      remote_o = fields_i.g3_fb;
        else if (g4_fb_hit) remote_o = fields_i.g4_fb;
        else if (ts2_o)     remote_o = fields_i.g4_fb;
    end
endmodule

// File: rtl/eqp_override_sel.sv
// Module: eqp_override_sel (top)
// Registers the local and remote preset decisions one clock after the
// inputs are sampled. Assumes all inputs are synchronous to clk and known
// once reset is released. Synchronous active-low reset clears all outputs.
module eqp_override_sel
    import eqp_pkg::*;
#(
    parameter int ITER_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ctrl_word,
    input  logic              is_endpoint,
    input  logic              rate_is_g4,
    input  logic [1:0]        eq_phase,
    input  logic [ITER_W-1:0] eq_iter,
    input  logic              spd_chg_rcfg,
    input  logic [3:0]        partner_preset,
    input  logic [3:0]        engine_preset,
    output logic [3:0]        local_preset,
    output logic [3:0]        remote_preset,
    output logic              use_eq_ts2,
    output logic              fb_valid
);
    eq_ctrl_t fields;
    preset_t  local_nxt;
    preset_t  remote_nxt;
    logic     fb_nxt;
    logic     ts2_nxt;
    logic     past_ok;

    eqp_ctrl_decode u_decode (
        .word_i   (ctrl_word),
        .fields_o (fields)
    );

    eqp_local_sel u_local (
        .fields_i     (fields),
        .rate_is_g4_i (rate_is_g4),
        .engine_i     (engine_preset),
        .local_o      (local_nxt)
    );

    eqp_remote_sel #(.ITER_W(ITER_W)) u_remote (
        .fields_i       (fields),
        .is_endpoint_i  (is_endpoint),
        .rate_is_g4_i   (rate_is_g4),
        .phase_i        (eq_phase),
        .iter_i         (eq_iter),
        .spd_chg_rcfg_i (spd_chg_rcfg),
        .partner_i      (partner_preset),
        .remote_o       (remote_nxt),
        .fb_valid_o     (fb_nxt),
        .ts2_o          (ts2_nxt)
    );

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            local_preset  <= '0;
            remote_preset <= '0;
            use_eq_ts2    <= 1'b0;
            fb_valid      <= 1'b0;
        end else begin
            local_preset  <= local_nxt;
            remote_preset <= remote_nxt;
            use_eq_ts2    <= ts2_nxt;
            fb_valid      <= fb_nxt;
        end
    end

    // Marks that the previous edge was out of reset, for history checks.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R10
    rp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(is_endpoint)) |-> (!fb_valid && !use_eq_ts2));

    // R8
    fb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ($past(eq_phase) != 2'd2 || $past(eq_iter) != '0)) |-> !fb_valid);

    // R7
    g4_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rate_is_g4) && ($past(partner_preset) == $past(ctrl_word[15:12])))
        |-> !fb_valid);

    // R3
    g4_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rate_is_g4) && $past(ctrl_word[16]))
        |-> (local_preset == $past(ctrl_word[20:17])));

    // R9
    ts2_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && use_eq_ts2) |-> (!$past(rate_is_g4) && $past(spd_chg_rcfg)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (local_preset == '0 && remote_preset == '0
                           && !fb_valid && !use_eq_ts2));
endmodule

// File: tb/eqp_override_sel_test.sv
module eqp_override_sel_test;
    localparam int CLK_PERIOD = 10;
    localparam int ITW = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [31:0]    ctrl_word;
    logic           is_endpoint;
    logic           rate_is_g4;
    logic [1:0]     eq_phase;
    logic [ITW-1:0] eq_iter;
    logic           spd_chg_rcfg;
    logic [3:0]     partner_preset;
    logic [3:0]     engine_preset;
    logic [3:0]     local_preset;
    logic [3:0]     remote_preset;
    logic           use_eq_ts2;
    logic           fb_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eqp_override_sel #(.ITER_W(ITW)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
        .is_endpoint(is_endpoint), .rate_is_g4(rate_is_g4),
        .eq_phase(eq_phase), .eq_iter(eq_iter), .spd_chg_rcfg(spd_chg_rcfg),
        .partner_preset(partner_preset), .engine_preset(engine_preset),
        .local_preset(local_preset), .remote_preset(remote_preset),
        .use_eq_ts2(use_eq_ts2), .fb_valid(fb_valid)
    );

    // Expected values from the requirements
    function automatic logic [3:0] exp_local();
        if (!rate_is_g4 && ctrl_word[5]) return ctrl_word[9:6];   // R2
        if (rate_is_g4 && ctrl_word[16]) return ctrl_word[20:17]; // R3
        return engine_preset;                                     // R4
    endfunction

    function automatic logic exp_fb3();
        return is_endpoint && eq_phase == 2'd2 && eq_iter == 0 && !rate_is_g4 && ctrl_word[0];
    endfunction

    function automatic logic exp_fb4();
        return is_endpoint && eq_phase == 2'd2 && eq_iter == 0 && rate_is_g4 && ctrl_word[11]
               && partner_preset != ctrl_word[15:12];
    endfunction

    function automatic logic exp_ts2();
        return is_endpoint && !rate_is_g4 && ctrl_word[10] && spd_chg_rcfg;
    endfunction

    function automatic logic [3:0] exp_remote();
        if (exp_fb3()) return ctrl_word[4:1];
        if (exp_fb4()) return ctrl_word[15:12];
        if (exp_ts2()) return ctrl_word[15:12];
        return 4'd0;
    endfunction

    task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Apply the current inputs for one edge and check all outputs.
    task automatic step_check();
        logic [3:0] el, er;
        logic ef, et;
        string lt, ft, tt, rt;
        el = exp_local(); er = exp_remote();
        ef = exp_fb3() || exp_fb4(); et = exp_ts2();
        lt = (!rate_is_g4 && ctrl_word[5]) ? "R2" : (rate_is_g4 && ctrl_word[16]) ? "R3" : "R4";
        if (!is_endpoint) ft = "R10";
        else if (eq_phase != 2'd2 || eq_iter != 0) ft = "R8";
        else if (rate_is_g4 && partner_preset == ctrl_word[15:12]) ft = "R7";
        else ft = rate_is_g4 ? "R6" : "R5";
        tt = is_endpoint ? "R9" : "R10";
        rt = ef ? (rate_is_g4 ? "R6" : "R5") : (et ? "R9" : "R10");
        @(posedge clk);
        @(negedge clk);
        check(lt, "local_preset", local_preset, el);
        check(ft, "fb_valid", {3'b0, fb_valid}, {3'b0, ef});
        check(tt, "use_eq_ts2", {3'b0, use_eq_ts2}, {3'b0, et});
        check(rt, "remote_preset", remote_preset, er);
    endtask

    task automatic set_in(input logic [31:0] w, input logic ep, input logic r4, input logic [1:0] ph,
                          input logic [ITW-1:0] it, input logic sc, input logic [3:0] pp, input logic [3:0] en);
        ctrl_word = w; is_endpoint = ep; rate_is_g4 = r4; eq_phase = ph;
        eq_iter = it; spd_chg_rcfg = sc; partner_preset = pp; engine_preset = en;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] hold_l, hold_r;
        logic hold_f, hold_t;
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        set_in(32'hFFFF_FFFF, 1'b1, 1'b0, 2'd2, '0, 1'b1, 4'h3, 4'h9);
        @(negedge clk); @(negedge clk);
        // R1 reset clears everything despite active inputs
        check("R1", "local_preset", local_preset, 4'd0);
        check("R1", "remote_preset", remote_preset, 4'd0);
        check("R1", "fb_valid", {3'b0, fb_valid}, 4'd0);
        check("R1", "use_eq_ts2", {3'b0, use_eq_ts2}, 4'd0);
        rst_n = 1'b1;

        // Directed: rate 3 override and feedback (R2, R5)
        set_in(32'h0000_0000 | (32'h1 << 5) | (32'hA << 6) | 32'h1 | (32'h6 << 1),
               1'b1, 1'b0, 2'd2, '0, 1'b0, 4'h0, 4'h4);
        step_check();
        // Directed: rate 4 override, feedback (R3, R6)
        set_in((32'h1 << 16) | (32'hC << 17) | (32'h1 << 11) | (32'h7 << 12),
               1'b1, 1'b1, 2'd2, '0, 1'b0, 4'h2, 4'h1);
        step_check();
        // R7 partner matches -> skipped
        set_in((32'h1 << 11) | (32'h7 << 12), 1'b1, 1'b1, 2'd2, '0, 1'b0, 4'h7, 4'h1);
        step_check();
        // R8 second iteration
        set_in(32'h1 | (32'h5 << 1), 1'b1, 1'b0, 2'd2, 3'd1, 1'b0, 4'h0, 4'h2);
        step_check();
        // R9 special TS2
        set_in((32'h1 << 10) | (32'hB << 12), 1'b1, 1'b0, 2'd0, '0, 1'b1, 4'h0, 4'h2);
        step_check();
        // R10 root port: all feedback enables ignored, override still works
        set_in(32'h0001_FFFF, 1'b0, 1'b0, 2'd2, '0, 1'b1, 4'h0, 4'h2);
        step_check();
        // R11 reserved bits have no effect
        set_in(32'h0012_3456, 1'b1, 1'b0, 2'd2, '0, 1'b1, 4'h1, 4'h8);
        step_check();
        hold_l = local_preset; hold_r = remote_preset; hold_f = fb_valid; hold_t = use_eq_ts2;
        ctrl_word = 32'hFFE0_0000 | 32'h0012_3456;
        @(posedge clk); @(negedge clk);
        check("R11", "local_preset", local_preset, hold_l);
        check("R11", "remote_preset", remote_preset, hold_r);
        check("R11", "fb_valid", {3'b0, fb_valid}, {3'b0, hold_f});
        check("R11", "use_eq_ts2", {3'b0, use_eq_ts2}, {3'b0, hold_t});
        // R12 latency: new override not visible until after the next edge
        set_in(32'h0, 1'b1, 1'b0, 2'd0, '0, 1'b0, 4'h0, 4'h3);
        @(posedge clk); @(negedge clk);
        ctrl_word = (32'h1 << 5) | (32'hE << 6);
        #1;
        check("R12", "local_preset before edge", local_preset, 4'h3);
        @(posedge clk); @(negedge clk);
        check("R12", "local_preset after edge", local_preset, 4'hE);

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            w = $urandom();
            ctrl_word      = w;
            is_endpoint    = ($urandom_range(0, 3) != 0);
            rate_is_g4     = $urandom_range(0, 1);
            eq_phase       = ($urandom_range(0, 1) == 0) ? 2'd2 : 2'($urandom_range(0, 3));
            eq_iter        = ($urandom_range(0, 1) == 0) ? '0 : ITW'($urandom_range(0, 7));
            spd_chg_rcfg   = $urandom_range(0, 1);
            partner_preset = ($urandom_range(0, 3) == 0) ? w[15:12] : 4'($urandom_range(0, 15));
            engine_preset  = 4'($urandom_range(0, 15));
            step_check();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule